// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port with a small memory-mapped register set. Each pin has an output value latch, a direction bit that turns its output enable on or off, and a readable, synchronized copy of its pad level. Software reads and writes registers through a single-cycle bus: a select, a write strobe, a byte address and a data word. Read data appears registered one clock after the read.

Every pin also carries an event detector. Its sensitivity is chosen by a two-bit code: low level, high level, rising edge or falling edge. Detected events collect in a sticky status word that software clears by writing ones. The events enabled by a mask word drive one interrupt line for pins 0 to 15 and one for pins 16 to 31. A third line is the OR of the two. Events are recorded whether or not the pin is masked, so a masked event stays pending until it is cleared.

Top module: `gpio_irq_port`

## Requirements
- R1: Byte offsets decode as 0x00 output latch, 0x04 direction, 0x08 pad levels, 0x0C sensitivity for pins 0-15, 0x10 sensitivity for pins 16-31, 0x14 mask and 0x18 status. The latch, direction, both sensitivity words and mask read back what was last written. All of them reset to zero, and read data is valid the cycle after the read strobe.
- R2: `pad_oe` equals the direction word (1 = output) and `pad_out` equals the output latch, one cycle after the write.
- R3: A read of offset 0x08 returns the pad inputs after a two-flop synchronizer, whatever the direction bits are. Writes to 0x08 change no register.
- R4: Pin p takes its code from the low sensitivity word when p < 16 and from the high word otherwise, at bits [2*(p mod 16)+1 : 2*(p mod 16)].
- R5: Code 00 sets the pin's status bit on every cycle its synchronized input is 0, and code 01 does so on every cycle it is 1. This includes the cycle in which that bit is being cleared.
- R6: Code 10 sets status once when the synchronized input goes from 0 to 1, and code 11 once when it goes from 1 to 0. A steady input sets nothing.
- R7: Writing offset 0x18 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. An event detected in the same cycle as its clear leaves the bit set. No status bit falls without such a write.
- R8: Status bits are set whatever the mask, and a change of sensitivity code does not clear them.
- R9: `irq_lo` is 1 when (status AND mask) is nonzero in bits 15:0, and `irq_hi` likewise for bits 31:16. Mask bit 1 enables the pin. Both lines are registered one cycle after the status word.
- R10: `irq_any` is the OR of `irq_lo` and `irq_hi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch to the pad drivers |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Enabled pending event among pins 0-15 |
| irq_hi | output | 1 | Enabled pending event among pins 16-31 |
| irq_any | output | 1 | OR of the two half lines |

## Verification
The status clear from the bus and the setting of a bit by its detector can fall on the same clock edge. The bench provokes this by timing a pad transition so that the synchronized edge is present exactly when the clear write is captured. It then repeats the transition with the write one cycle later. In the first case the bit must remain set, and in the second it must read back as zero. Level-mode pins see the same collision on every clear, and the randomized passes check that those bits read back set immediately after being cleared.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int OFS_W = 5;

  typedef enum logic [1:0] {
    SENS_LOW  = 2'b00,
    SENS_HIGH = 2'b01,
    SENS_RISE = 2'b10,
    SENS_FALL = 2'b11
  } sens_e;

  typedef enum logic [OFS_W-1:0] {
    OFS_OUT    = 5'h00,
    OFS_DIR    = 5'h04,
    OFS_PAD    = 5'h08,
    OFS_SENS_L = 5'h0C,
    OFS_SENS_H = 5'h10,
    OFS_MASK   = 5'h14,
    OFS_STAT   = 5'h18
  } reg_ofs_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect import gpio_pkg::*; #(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   level,
  input  logic [NPIN-1:0]   sens_lo,
  input  logic [NPIN-1:0]   sens_hi,
  output logic [NPIN-1:0]   hit
);

  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int FIELD = 2 * (i % HALF);
    logic [1:0] code;

    if (i < HALF) begin : g_lo
      assign code = sens_lo[FIELD +: 2];
    end else begin : g_hi
      assign code = sens_hi[FIELD +: 2];
    end

    always_comb begin
      case (sens_e'(code))
        SENS_LOW:  hit[i] = ~level[i];
        SENS_HIGH: hit[i] =  level[i];
        SENS_RISE: hit[i] =  level[i] & ~prev_q[i];
        SENS_FALL: hit[i] = ~level[i] &  prev_q[i];
        default:   hit[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs import gpio_pkg::*; #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_level,
  input  logic [NPIN-1:0]   hit,
  output logic [NPIN-1:0]   out_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   sens_lo_q,
  output logic [NPIN-1:0]   sens_hi_q,
  output logic [NPIN-1:0]   mask_q,
  output logic [NPIN-1:0]   stat_q
);

  logic wr_en, rd_en;
  logic sel_out, sel_dir, sel_pad, sel_sl, sel_sh, sel_mask, sel_stat;
  logic [NPIN-1:0] clr_vec;
  logic [NPIN-1:0] rd_mux;

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  assign sel_out  = (bus_addr == ADDR_W'(OFS_OUT));
  assign sel_dir  = (bus_addr == ADDR_W'(OFS_DIR));
  assign sel_pad  = (bus_addr == ADDR_W'(OFS_PAD));
  assign sel_sl   = (bus_addr == ADDR_W'(OFS_SENS_L));
  assign sel_sh   = (bus_addr == ADDR_W'(OFS_SENS_H));
  assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));

  assign clr_vec = (wr_en && sel_stat) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= '0;
      dir_q     <= '0;
      sens_lo_q <= '0;
      sens_hi_q <= '0;
      mask_q    <= '0;
    end else if (wr_en) begin
      if (sel_out)  out_q     <= bus_wdata;
      if (sel_dir)  dir_q     <= bus_wdata;
      if (sel_sl)   sens_lo_q <= bus_wdata;
      if (sel_sh)   sens_hi_q <= bus_wdata;
      if (sel_mask) mask_q    <= bus_wdata;
    end
  end

  // detection wins over a clear landing on the same edge
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_vec) | hit;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_out)  rd_mux = out_q;
    if (sel_dir)  rd_mux = dir_q;
    if (sel_pad)  rd_mux = pad_level;
    if (sel_sl)   rd_mux = sens_lo_q;
    if (sel_sh)   rd_mux = sens_hi_q;
    if (sel_mask) rd_mux = mask_q;
    if (sel_stat) rd_mux = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] stat,
  input  logic [NPIN-1:0] mask,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            irq_any
);

  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0] pend;
  logic [1:0]      half_req;

  assign pend = stat & mask;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_req[h] = |pend[h*HALF +: HALF];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      irq_lo  <= half_req[0];
      irq_hi  <= half_req[1];
      irq_any <= |pend;
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port import gpio_pkg::*; #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_any
);

  logic [NPIN-1:0] sync_q;
  logic [NPIN-1:0] hit_vec;
  logic [NPIN-1:0] out_q, dir_q, sens_lo_q, sens_hi_q, mask_q, stat_q;

  gpio_sync #(.WIDTH(NPIN), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (sync_q)
  );

  gpio_detect #(.NPIN(NPIN)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .level   (sync_q),
    .sens_lo (sens_lo_q),
    .sens_hi (sens_hi_q),
    .hit     (hit_vec)
  );

  gpio_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_level (sync_q),
    .hit       (hit_vec),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .sens_lo_q (sens_lo_q),
    .sens_hi_q (sens_hi_q),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
  );

  gpio_irq_out #(.NPIN(NPIN)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .stat    (stat_q),
    .mask    (mask_q),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi),
    .irq_any (irq_any)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk import gpio_pkg::*; #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pad_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic              irq_any,
  input logic [NPIN-1:0]   stat_q,
  input logic [NPIN-1:0]   mask_q,
  input logic [NPIN-1:0]   sync_q,
  input logic [NPIN-1:0]   hit_vec
);

  localparam int HALF = NPIN / 2;

  logic stat_wr, dir_wr, pad_rd;
  assign stat_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign dir_wr  = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_DIR));
  assign pad_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_PAD));

  // R7
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));

  // R5
  hit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(hit_vec)) == $past(hit_vec)));

  // R9
  irq_lo_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_lo == (|$past(stat_q[HALF-1:0] & mask_q[HALF-1:0]))));

  // R9
  irq_hi_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_hi == (|$past(stat_q[NPIN-1:HALF] & mask_q[NPIN-1:HALF]))));

  // R10
  irq_any_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_lo | irq_hi));

  // R2
  dir_oe_chk: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> (pad_oe == $past(bus_wdata)));

  // R3
  pad_rd_chk: assert property (@(posedge clk) disable iff (rst)
    pad_rd |=> (bus_rdata == $past(sync_q)));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .irq_any   (irq_any),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .sync_q    (sync_q),
  .hit_vec   (hit_vec)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_SL = 5'h0C, A_SH = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] code_of(input logic [31:0] lo, input logic [31:0] hi, input int p);
    return (p < 16) ? lo[2*p +: 2] : hi[2*(p-16) +: 2];
  endfunction

  // bits a level-mode pin holds set with input p
  function automatic logic [31:0] lvl_hold(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] p);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (code_of(lo, hi, i))
        2'b00: r[i] = ~p[i];
        2'b01: r[i] =  p[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  // expected status: held p0, cleared, then moved to p1
  function automatic logic [31:0] evt(input logic [31:0] lo, input logic [31:0] hi,
                                      input logic [31:0] p0, input logic [31:0] p1);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (code_of(lo, hi, i))
        2'b00: r[i] = ~p0[i] | ~p1[i];
        2'b01: r[i] =  p0[i] |  p1[i];
        2'b10: r[i] = ~p0[i] &  p1[i];
        default: r[i] = p0[i] & ~p1[i];
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi, p0, p1, s, w, m;
    void'($urandom(32'd24681));
    idle(4);
    @(negedge clk) rst = 1'b0;
    idle(4);

    // R1 reset values
    rd(A_OUT, d);  chk("R1 reset out", d, 32'h0);
    rd(A_DIR, d);  chk("R1 reset dir", d, 32'h0);
    rd(A_SL, d);   chk("R1 reset sens_lo", d, 32'h0);
    rd(A_SH, d);   chk("R1 reset sens_hi", d, 32'h0);
    rd(A_MASK, d); chk("R1 reset mask", d, 32'h0);
    chk("R9 reset irq", {29'd0, irq_lo, irq_hi, irq_any}, 32'h0);
    // R5 low-level code 00 with all pads low sets every bit
    rd(A_STAT, d); chk("R5 low level after reset", d, 32'hFFFF_FFFF);

    // R1 R2 R3 readback, direction, pad sampling, pad writes ignored
    for (int k = 0; k < 12; k++) begin
      d = $urandom; w = $urandom; p0 = $urandom;
      wr(A_OUT, d); wr(A_DIR, w);
      @(negedge clk) pad_in = p0;
      chk("R2 pad_out", pad_out, d);
      chk("R2 pad_oe", pad_oe, w);
      idle(3);
      wr(A_PAD, ~p0);
      rd(A_PAD, s); chk("R3 pad level", s, p0);
      rd(A_OUT, s); chk("R3 pad write ignored out", s, d);
      rd(A_DIR, s); chk("R1 dir readback", s, w);
      m = $urandom; wr(A_MASK, m); rd(A_MASK, s); chk("R1 mask readback", s, m);
    end
    wr(A_MASK, 32'h0);

    // R4 R5 R6 R7 R8 R9 R10 random sensitivity mix
    for (int k = 0; k < 40; k++) begin
      lo = $urandom; hi = $urandom;
      if (k < 4) begin lo = {16{2'b10}}; hi = {16{2'b11}}; end
      wr(A_SL, lo); wr(A_SH, hi);
      rd(A_SL, d); chk("R1 sens_lo readback", d, lo);
      p0 = $urandom;
      @(negedge clk) pad_in = p0;
      idle(6);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); chk("R5 level sets during clear", d, lvl_hold(lo, hi, p0));
      p1 = (k % 3 == 0) ? p0 : $urandom;
      @(negedge clk) pad_in = p1;
      idle(6);
      s = evt(lo, hi, p0, p1);
      rd(A_STAT, d); chk("R6 R4 events per code", d, s);
      w = $urandom;
      wr(A_STAT, w);
      s = (s & ~w) | lvl_hold(lo, hi, p1);
      rd(A_STAT, d); chk("R7 partial clear", d, s);
      m = $urandom;
      if (k % 5 == 0) m = 32'h0;
      wr(A_MASK, m);
      idle(3);
      chk("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |(s[15:0] & m[15:0])});
      chk("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |(s[31:16] & m[31:16])});
      chk("R10 irq_any", {31'd0, irq_any}, {31'd0, |(s & m)});
      wr(A_SL, {16{2'b10}}); wr(A_SH, {16{2'b10}});
      rd(A_STAT, d); chk("R8 sens change keeps status", d, s);
      wr(A_MASK, 32'h0);
    end

    // R9 upper half only, R4 field for pin 20 in high word
    wr(A_SL, 32'hFFFF_FFFF); wr(A_SH, 32'hFFFF_FEFF);
    @(negedge clk) pad_in = 32'h0;
    idle(6);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_MASK, 32'hFFFF_FFFF);
    @(negedge clk) pad_in = 32'h0010_0000;
    idle(6);
    rd(A_STAT, d); chk("R4 pin20 rising field", d, 32'h0010_0000);
    chk("R9 upper only lo", {31'd0, irq_lo}, 32'h0);
    chk("R9 upper only hi", {31'd0, irq_hi}, 32'h1);
    chk("R10 upper only any", {31'd0, irq_any}, 32'h1);
    wr(A_MASK, 32'h0);
    idle(3);
    chk("R8 masked still pending irq", {31'd0, irq_any}, 32'h0);
    rd(A_STAT, d); chk("R8 masked still pending", d, 32'h0010_0000);

    // R7 clear coincident with edge detection
    wr(A_SL, {16{2'b10}}); wr(A_SH, {16{2'b10}});
    @(negedge clk) pad_in = 32'h0;
    idle(6);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk) pad_in = 32'h1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_STAT, d); chk("R7 event wins over clear", d, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk) pad_in = 32'h5;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h4;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_STAT, d); chk("R7 clear one cycle after event", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule